// File: doc/BRIEF.md
# Command-Driven Memory Test Sequencer

This block exercises an external single-port memory on behalf of a test controller. It takes a stream of commands and drives the memory's address, write-data and read/not-write pins. Each command carries a 3-bit operation, an address and a data value. For a read it compares the returned word with the value the command supplied. It also watches a per-word "known" flag that the memory raises for any location written since the last release. Every miscompare gives a one-cycle report carrying the address and the word that came back. A saturating counter totals the miscompares, and a done/pass pair summarises the run.

The controller marks each new command by flipping a single event bit. That bit is the command's valid indication: a command is pending whenever the event bit differs from the value last taken. `cmd_ready` is the back-pressure signal. A pending command is taken only on a cycle where `cmd_ready` is high. While `cmd_ready` is low the controller must hold the operation, address, data and event bit steady. A flip made during a busy period waits and is taken once `cmd_ready` returns. Flipping twice while waiting cancels the command.

An init command starts a built-in routine that needs no further commands. It fills two adjacent logical pages with a pattern computed from the address, reads every word back and checks it. It then reads a location of the following page, which must not have been written, and expects the memory to report it as unknown. The expected values are computed again from the address, so the routine stores no data.

Top module: `memtest_sequencer`

## Requirements
- R1: After reset `cmd_ready`=1, `mem_rnw`=1, `mem_release`=0, `err_pulse`=0, `err_count`=0, `done`=0 and `pass`=0.
- R2: A command is taken only on a cycle where `cmd_ready` is high and `cmd_evt` differs from the event value last taken. A flip is taken at most once. Changing the other command fields without flipping `cmd_evt` starts nothing. `cmd_ready` is low on the cycle after a command is taken, and stays low until that command has finished.
- R3: `cmd_op` codes: 0 = init, 1 = read, 2 = write, 3 = dealloc, 4 = end_test. Codes 5 to 7 are taken and have no effect on the memory pins, the error count or `done`.
- R4: A write drives `mem_rnw`=0 for exactly one cycle, two cycles after the cycle in which the command was taken. In that cycle `mem_addr` and `mem_d` equal the command's address and data.
- R5: A read holds `mem_addr` with `mem_rnw`=1 for RD_LAT cycles (default 2) and samples the memory in the last of them. It is a miscompare if `mem_q_known`=0 or if `mem_q` differs from the command's data. `cmd_ready` returns RD_LAT+2 cycles after the cycle in which the command was taken.
- R6: Every miscompare produces its own one-cycle `err_pulse`. With the pulse, `err_addr` and `err_data` give the address read and the word sampled. Both hold their values until the next miscompare.
- R7: `err_count` (ERR_W bits, default 16) adds one per miscompare, stops at all ones, and is cleared by init.
- R8: Init takes page P from `cmd_addr` bits above PAGE_W (a page is 2^PAGE_W words, default 16). It first writes every word of pages P and P+1 in ascending address order, each with data = address XOR PATTERN (default 16'hA5C3). It then reads those words back in the same order and checks each against the same pattern. Finally it reads offset 0 of page P+2, which is a miscompare if `mem_q_known`=1.
- R9: Dealloc raises `mem_release` for one cycle, two cycles after the cycle in which the command was taken.
- R10: end_test sets `done`, which stays set until the next init. `pass` is 1 exactly when `done`=1 and `err_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Operation code of the offered command |
| cmd_addr | input | ADDR_W | Command address (init: page select in upper bits) |
| cmd_data | input | DATA_W | Write data, or expected read data |
| cmd_evt | input | 1 | Event bit; a flip marks a new command |
| cmd_ready | output | 1 | High when a pending command can be taken |
| mem_addr | output | ADDR_W | Memory address |
| mem_d | output | DATA_W | Memory write data |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| mem_release | output | 1 | One-cycle request to free all memory contents |
| mem_q | input | DATA_W | Memory read data |
| mem_q_known | input | 1 | 1 when the addressed word has been written |
| err_pulse | output | 1 | One cycle per miscompare |
| err_addr | output | ADDR_W | Address of the latest miscompare |
| err_data | output | DATA_W | Word sampled at the latest miscompare |
| err_count | output | ERR_W | Saturating miscompare total |
| done | output | 1 | Set by end_test |
| pass | output | 1 | done with zero errors |

## Verification
The bench targets the handshake edges. It checks that a changed field without a flip starts nothing, and that an undefined code takes a slot but leaves no write behind. A decoder that acted on fields alone, or that treated spare codes as writes, would leave a stray write strobe or overwrite a stored word. It counts `cmd_ready` cycles around a read, because a sequencer that sampled early would release the next command while the memory was still settling. It injects a single corrupted word and a pre-written probe location into the built-in routine and expects exactly two reports with the right addresses. A routine that stopped at the first miscompare, or that never checked the unknown flag, would report fewer. A long run of failing reads shows the counter stopping at all ones instead of wrapping to a small value.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_DEALLOC = 3'd3,
    OP_END     = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_BWR,
    ST_BRD,
    ST_PROBE
  } st_e;
endpackage

// File: rtl/memseq_cmd_in.sv
module memseq_cmd_in #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              evt_in,
  input  logic              eng_idle,
  output logic              ready,
  output logic              acc_valid,
  output logic [2:0]        acc_op,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data
);
  logic last_evt;

  assign ready = eng_idle && !acc_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_evt  <= 1'b0;
      acc_valid <= 1'b0;
      acc_op    <= '0;
      acc_addr  <= '0;
      acc_data  <= '0;
    end else begin
      acc_valid <= 1'b0;
      if (ready && (evt_in != last_evt)) begin
        last_evt  <= evt_in;
        acc_valid <= 1'b1;
        acc_op    <= op_in;
        acc_addr  <= addr_in;
        acc_data  <= data_in;
      end
    end
  end

  // R2: a taken command is never followed by another on the next cycle
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid);

  // R2: after a take, the stored event bit matches the flag that was offered
  a_r2_flip_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (evt_in != last_evt)) |=> (last_evt == $past(evt_in)));
endmodule

// File: rtl/memseq_engine.sv
module memseq_engine
  import memseq_pkg::*;
#(
  parameter int              ADDR_W  = 10,
  parameter int              DATA_W  = 16,
  parameter int              PAGE_W  = 4,
  parameter int              RD_LAT  = 2,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [2:0]        acc_op,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              eng_idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_d,
  output logic              mem_rnw,
  output logic              mem_release,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              mem_q_known,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data,
  output logic              tally_clr,
  output logic              end_pulse
);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int IDX_W  = PAGE_W + 1;
  localparam int WALK   = 2 ** IDX_W;
  localparam int LAT_W  = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WALK - 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(RD_LAT - 1);

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return DATA_W'(a) ^ PATTERN;
  endfunction

  function automatic logic [ADDR_W-1:0] walk_addr(input logic [PG_W-1:0] pg,
                                                  input logic [IDX_W-1:0] i);
    logic [PG_W-1:0] p;
    p = pg + PG_W'(i[PAGE_W]);
    return {p, i[PAGE_W-1:0]};
  endfunction

  st_e               state;
  logic [PG_W-1:0]   base_pg;
  logic [IDX_W-1:0]  idx;
  logic [LAT_W-1:0]  lat;
  logic [DATA_W-1:0] exp_data;
  logic              exp_known;

  logic [IDX_W-1:0]  idx_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] init_addr;
  logic [ADDR_W-1:0] probe_addr;
  logic [PG_W-1:0]   probe_pg;
  logic              miss;
  logic              reading;

  always_comb begin
    idx_nxt    = idx + 1'b1;
    addr_nxt   = walk_addr(base_pg, idx_nxt);
    init_addr  = {acc_addr[ADDR_W-1:PAGE_W], PAGE_W'(0)};
    probe_pg   = base_pg + PG_W'(2);
    probe_addr = {probe_pg, PAGE_W'(0)};
    miss       = exp_known ? (!mem_q_known || (mem_q != exp_data)) : mem_q_known;
    reading    = (state == ST_RD) || (state == ST_BRD) || (state == ST_PROBE);
  end

  assign eng_idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      base_pg     <= '0;
      idx         <= '0;
      lat         <= '0;
      exp_data    <= '0;
      exp_known   <= 1'b1;
      mem_addr    <= '0;
      mem_d       <= '0;
      mem_rnw     <= 1'b1;
      mem_release <= 1'b0;
      err_pulse   <= 1'b0;
      err_addr    <= '0;
      err_data    <= '0;
      tally_clr   <= 1'b0;
      end_pulse   <= 1'b0;
    end else begin
      mem_release <= 1'b0;
      err_pulse   <= 1'b0;
      tally_clr   <= 1'b0;
      end_pulse   <= 1'b0;
      case (state)
        ST_IDLE: if (acc_valid) begin
          case (acc_op)
            OP_WRITE: begin
              mem_addr <= acc_addr;
              mem_d    <= acc_data;
              mem_rnw  <= 1'b0;
              state    <= ST_WR;
            end
            OP_READ: begin
              mem_addr  <= acc_addr;
              exp_data  <= acc_data;
              exp_known <= 1'b1;
              lat       <= '0;
              state     <= ST_RD;
            end
            OP_DEALLOC: mem_release <= 1'b1;
            OP_END:     end_pulse   <= 1'b1;
            OP_INIT: begin
              tally_clr <= 1'b1;
              base_pg   <= acc_addr[ADDR_W-1:PAGE_W];
              idx       <= '0;
              mem_addr  <= init_addr;
              mem_d     <= pat(init_addr);
              mem_rnw   <= 1'b0;
              state     <= ST_BWR;
            end
            default: ;
          endcase
        end
        ST_WR: begin
          mem_rnw <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_BWR: begin
          if (idx == IDX_LAST) begin
            idx       <= '0;
            mem_rnw   <= 1'b1;
            mem_addr  <= walk_addr(base_pg, '0);
            exp_data  <= pat(walk_addr(base_pg, '0));
            exp_known <= 1'b1;
            lat       <= '0;
            state     <= ST_BRD;
          end else begin
            idx      <= idx_nxt;
            mem_addr <= addr_nxt;
            mem_d    <= pat(addr_nxt);
          end
        end
        ST_RD, ST_BRD, ST_PROBE: begin
          if (lat != LAT_LAST) begin
            lat <= lat + 1'b1;
          end else begin
            lat       <= '0;
            err_pulse <= miss;
            if (miss) begin
              err_addr <= mem_addr;
              err_data <= mem_q;
            end
            if (state == ST_BRD) begin
              if (idx == IDX_LAST) begin
                mem_addr  <= probe_addr;
                exp_known <= 1'b0;
                state     <= ST_PROBE;
              end else begin
                idx      <= idx_nxt;
                mem_addr <= addr_nxt;
                exp_data <= pat(addr_nxt);
              end
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a single write strobe returns to read on the next cycle
  a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR) |=> (mem_rnw && (state == ST_IDLE)));

  // R5: the address stays put and in read mode while the read settles
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && (lat != '0)) |-> ($stable(mem_addr) && mem_rnw));

  // R8: the fill only ever touches the two selected pages
  a_r8_fill_pages: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BWR) |-> ((mem_addr[ADDR_W-1:PAGE_W] == base_pg) ||
                           (mem_addr[ADDR_W-1:PAGE_W] == base_pg + PG_W'(1))));

  // R9: the release request lasts one cycle
  a_r9_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_release |=> !mem_release);

  // R6: a report appears only right after a sampling cycle of a read
  a_r6_report_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(reading && (lat == LAT_LAST)));
endmodule

// File: rtl/memseq_tally.sv
module memseq_tally #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             end_pulse,
  input  logic             err_pulse,
  output logic [ERR_W-1:0] err_count,
  output logic             done,
  output logic             pass
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_count <= '0;
      done      <= 1'b0;
    end else if (clr) begin
      err_count <= '0;
      done      <= 1'b0;
    end else begin
      if (err_pulse && (err_count != CNT_MAX)) err_count <= err_count + 1'b1;
      if (end_pulse) done <= 1'b1;
    end
  end

  assign pass = done && (err_count == '0);

  // R7: the counter holds at its top value
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == CNT_MAX) && !clr) |=> (err_count == CNT_MAX));

  // R7: without a miscompare or a clear the total does not move
  a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !err_pulse) |=> $stable(err_count));

  // R10: done is sticky until the next init
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);
endmodule

// File: rtl/memtest_sequencer.sv
module memtest_sequencer
  import memseq_pkg::*;
#(
  parameter int                ADDR_W  = 10,
  parameter int                DATA_W  = 16,
  parameter int                PAGE_W  = 4,
  parameter int                RD_LAT  = 2,
  parameter int                ERR_W   = 16,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_evt,
  output logic              cmd_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_d,
  output logic              mem_rnw,
  output logic              mem_release,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              mem_q_known,
  output logic              err_pulse,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_data,
  output logic [ERR_W-1:0]  err_count,
  output logic              done,
  output logic              pass
);
  logic              eng_idle;
  logic              acc_valid;
  logic [2:0]        acc_op;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;
  logic              tally_clr;
  logic              end_pulse;

  memseq_cmd_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .op_in(cmd_op), .addr_in(cmd_addr), .data_in(cmd_data), .evt_in(cmd_evt),
    .eng_idle(eng_idle), .ready(cmd_ready),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr), .acc_data(acc_data)
  );

  memseq_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .RD_LAT(RD_LAT), .PATTERN(PATTERN)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr), .acc_data(acc_data),
    .eng_idle(eng_idle),
    .mem_addr(mem_addr), .mem_d(mem_d), .mem_rnw(mem_rnw), .mem_release(mem_release),
    .mem_q(mem_q), .mem_q_known(mem_q_known),
    .err_pulse(err_pulse), .err_addr(err_addr), .err_data(err_data),
    .tally_clr(tally_clr), .end_pulse(end_pulse)
  );

  memseq_tally #(.ERR_W(ERR_W)) u_tally (
    .clk(clk), .rst_n(rst_n),
    .clr(tally_clr), .end_pulse(end_pulse), .err_pulse(err_pulse),
    .err_count(err_count), .done(done), .pass(pass)
  );

  // R2: no command can be taken while an operation is in flight
  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |-> !cmd_ready);
endmodule

// File: tb/memtest_sequencer_test.sv
module memtest_sequencer_test;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int PW = 4;
  localparam int LAT = 2;
  localparam int EW = 8;
  localparam logic [DW-1:0] PAT = 16'hA5C3;
  localparam int WORDS = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_evt = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_d;
  logic          mem_rnw;
  logic          mem_release;
  logic [DW-1:0] mem_q;
  logic          mem_q_known;
  logic          err_pulse;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_data;
  logic [EW-1:0] err_count;
  logic          done;
  logic          pass;

  always #5 clk = ~clk;

  memtest_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .RD_LAT(LAT), .ERR_W(EW), .PATTERN(PAT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_evt(cmd_evt), .cmd_ready(cmd_ready), .mem_addr(mem_addr), .mem_d(mem_d),
    .mem_rnw(mem_rnw), .mem_release(mem_release), .mem_q(mem_q), .mem_q_known(mem_q_known),
    .err_pulse(err_pulse), .err_addr(err_addr), .err_data(err_data),
    .err_count(err_count), .done(done), .pass(pass)
  );

  // memory model
  logic [DW-1:0] mem [WORDS];
  logic          kn  [WORDS];
  int            flip_addr = -1;

  always @(posedge clk) begin
    if (!rst_n || mem_release) begin
      for (int i = 0; i < WORDS; i++) kn[i] <= 1'b0;
    end else if (!mem_rnw) begin
      mem[mem_addr] <= mem_d;
      kn[mem_addr]  <= 1'b1;
    end
  end

  assign mem_q = mem[mem_addr] ^ ((int'(mem_addr) == flip_addr) ? 16'h0001 : 16'h0000);
  assign mem_q_known = kn[mem_addr];

  // miscompare monitor
  int            seen = 0;
  logic [AW-1:0] last_ea = '0, prev_ea = '0;
  logic [DW-1:0] last_ed = '0, prev_ed = '0;
  always @(negedge clk) begin
    if (rst_n && err_pulse) begin
      seen    <= seen + 1;
      prev_ea <= last_ea;
      prev_ed <= last_ed;
      last_ea <= err_addr;
      last_ed <= err_data;
    end
  end

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic toggle(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op   = op;
    cmd_addr = a;
    cmd_data = d;
    cmd_evt  = ~cmd_evt;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    toggle(op, a, d);
    wait_idle();
  endtask

  task automatic t_reset();
    check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    check(mem_rnw == 1'b1, "R1 rnw", int'(mem_rnw), 1);
    check(mem_release == 1'b0, "R1 release", int'(mem_release), 0);
    check(err_pulse == 1'b0, "R1 err_pulse", int'(err_pulse), 0);
    check(err_count == '0, "R1 count", int'(err_count), 0);
    check(done == 1'b0 && pass == 1'b0, "R1 done/pass", int'({done, pass}), 0);
  endtask

  task automatic t_write();
    toggle(3'd2, 10'd5, 16'd1234);
    @(negedge clk);
    check(mem_rnw == 1'b1, "R4 no strobe on take cycle", int'(mem_rnw), 1);
    check(cmd_ready == 1'b0, "R2 ready low after take", int'(cmd_ready), 0);
    @(negedge clk);
    check(mem_rnw == 1'b0, "R4 strobe", int'(mem_rnw), 0);
    check(mem_addr == 10'd5, "R4 addr", int'(mem_addr), 5);
    check(mem_d == 16'd1234, "R4 data", int'(mem_d), 1234);
    @(negedge clk);
    check(mem_rnw == 1'b1, "R4 strobe one cycle", int'(mem_rnw), 1);
    check(cmd_ready == 1'b1, "R2 ready back", int'(cmd_ready), 1);
  endtask

  task automatic t_read_good();
    int s0;
    s0 = seen;
    toggle(3'd1, 10'd5, 16'd1234);
    for (int k = 0; k <= LAT; k++) begin
      @(negedge clk);
      check(cmd_ready == 1'b0, "R5 busy during read", int'(cmd_ready), 0);
    end
    @(negedge clk);
    check(cmd_ready == 1'b1, "R5 ready after latency", int'(cmd_ready), 1);
    @(negedge clk);
    check(seen == s0, "R5 matching read no report", seen, s0);
    check(err_count == 0, "R7 count stays 0", int'(err_count), 0);
  endtask

  task automatic t_read_bad();
    int s0;
    s0 = seen;
    send(3'd1, 10'd5, 16'h9999);
    check(seen == s0 + 1, "R6 one report", seen, s0 + 1);
    check(last_ea == 10'd5, "R6 err_addr", int'(last_ea), 5);
    check(last_ed == 16'd1234, "R6 err_data", int'(last_ed), 1234);
    check(err_count == 1, "R7 count 1", int'(err_count), 1);
    send(3'd1, 10'd77, 16'd0);
    check(seen == s0 + 2, "R5 unknown word miscompares", seen, s0 + 2);
    check(err_count == 2, "R7 count 2", int'(err_count), 2);
  endtask

  task automatic t_ignore();
    int s0;
    bit strobe;
    s0 = seen;
    strobe = 1'b0;
    toggle(3'd6, 10'd5, 16'hFFFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!mem_rnw || mem_release) strobe = 1'b1;
    end
    check(!strobe, "R3 spare code no memory action", int'(strobe), 0);
    check(cmd_ready == 1'b1, "R3 spare code consumed", int'(cmd_ready), 1);
    cmd_op = 3'd2; cmd_addr = 10'd5; cmd_data = 16'd0;
    strobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!mem_rnw || !cmd_ready) strobe = 1'b1;
    end
    check(!strobe, "R2 fields without flip start nothing", int'(strobe), 0);
    send(3'd1, 10'd5, 16'd1234);
    check(seen == s0, "R3 word untouched", seen, s0);
    check(err_count == 2 && done == 1'b0, "R3 count/done unchanged", int'(err_count), 2);
  endtask

  task automatic t_dealloc();
    toggle(3'd3, 10'd0, 16'd0);
    @(negedge clk);
    check(mem_release == 1'b0, "R9 not yet", int'(mem_release), 0);
    @(negedge clk);
    check(mem_release == 1'b1, "R9 release", int'(mem_release), 1);
    @(negedge clk);
    check(mem_release == 1'b0, "R9 one cycle", int'(mem_release), 0);
    send(3'd1, 10'd5, 16'd1234);
    check(err_count == 3, "R9 released word unknown", int'(err_count), 3);
  endtask

  task automatic t_end();
    send(3'd4, 10'd0, 16'd0);
    check(done == 1'b1, "R10 done", int'(done), 1);
    check(pass == 1'b0, "R10 no pass with errors", int'(pass), 0);
  endtask

  task automatic t_init_clean();
    int s0;
    bit bad;
    send(3'd3, 10'd0, 16'd0);
    s0 = seen;
    send(3'd0, 10'd48, 16'd0);
    check(err_count == 0, "R7 init clears count", int'(err_count), 0);
    check(done == 1'b0, "R10 init clears done", int'(done), 0);
    check(seen == s0, "R8 clean run no reports", seen, s0);
    bad = 1'b0;
    for (int i = 48; i < 80; i++)
      if (!kn[i] || mem[i] != (DW'(i) ^ PAT)) bad = 1'b1;
    check(!bad, "R8 pattern across two pages", int'(bad), 0);
    check(kn[80] == 1'b0, "R8 probe page not written", int'(kn[80]), 0);
    send(3'd4, 10'd0, 16'd0);
    check(pass == 1'b1, "R10 pass", int'(pass), 1);
  endtask

  task automatic t_init_faults();
    int s0;
    send(3'd3, 10'd0, 16'd0);
    send(3'd2, 10'd144, 16'd0);
    flip_addr = 115;
    s0 = seen;
    send(3'd0, 10'd112, 16'd0);
    flip_addr = -1;
    check(seen == s0 + 2, "R8 both faults reported", seen, s0 + 2);
    check(err_count == 2, "R7 count of two", int'(err_count), 2);
    check(prev_ea == 10'd115, "R6 first fault addr", int'(prev_ea), 115);
    check(prev_ed == ((16'd115 ^ PAT) ^ 16'd1), "R6 first fault data",
          int'(prev_ed), int'((16'd115 ^ PAT) ^ 16'd1));
    check(last_ea == 10'd144, "R8 probe flagged known word", int'(last_ea), 144);
  endtask

  task automatic t_saturate();
    int s0;
    send(3'd3, 10'd0, 16'd0);
    s0 = seen;
    for (int k = 0; k < 260; k++) send(3'd1, 10'd0, 16'd0);
    check(seen == s0 + 260, "R6 every miscompare reported", seen, s0 + 260);
    check(err_count == 8'hFF, "R7 saturates", int'(err_count), 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_good();
    t_read_bad();
    t_ignore();
    t_dealloc();
    t_end();
    t_init_clean();
    t_init_faults();
    t_saturate();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule